// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is a parameterised register, eight bits wide by default. On each rising clock edge it loads in parallel, shifts toward the high end, shifts toward the low end, or holds. The parallel data pins are shared. The register drives them as outputs in normal operation and samples them as inputs when the load code is selected. For that reason the load code also switches the bus drivers off. The bus is modelled as split ports: an input vector, an output vector that always carries the register contents, and an output-enable signal that says when a pad driver may put that vector on the shared pins.

Two serial taps, one on the lowest bit and one on the highest bit, are never disabled. Feeding the high tap of one instance into the low-end serial input of a second instance, and the second instance's low tap back into the first instance's high-end serial input, gives a shifter of twice the width that works in both directions. An active-low asynchronous reset clears every bit at once. It wins over both the clock and the mode inputs.

Top module: `usr_shift_reg`

## Requirements
- R1: With mode_i = 2'b11, a rising clock edge copies bus_i into the register.
- R2: With mode_i = 2'b01, a rising clock edge moves each bit n to bit n+1, and sr_i enters bit 0.
- R3: With mode_i = 2'b10, a rising clock edge moves each bit n to bit n-1, and sl_i enters bit WIDTH-1.
- R4: With mode_i = 2'b00, the register keeps its value across clock edges.
- R5: While rst_ni is low, every bit reads 0 straight away, with no clock edge needed. Clock edges and any mode code do not change this while reset is held.
- R6: bus_oe_o is high only when oe1_ni and oe2_ni are both low and mode_i is not 2'b11. A high on either enable, or the load code, forces it low.
- R7: bus_o always equals the register contents. Load, shift, hold and reset work the same whether bus_oe_o is high or low.
- R8: q_lo_o always equals register bit 0 and q_hi_o always equals bit WIDTH-1, whatever the output enables are.
- R9: Two instances chained through the serial taps and inputs act as one 2*WIDTH-bit register, in both shift directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operation code: 00 hold, 01 shift up, 10 shift down, 11 load |
| oe1_ni | input | 1 | Bus output enable, active low |
| oe2_ni | input | 1 | Second bus output enable, active low |
| sr_i | input | 1 | Serial input entering bit 0 on a shift up |
| sl_i | input | 1 | Serial input entering bit WIDTH-1 on a shift down |
| bus_i | input | WIDTH | Values sampled from the shared pins |
| bus_o | output | WIDTH | Register contents to drive onto the shared pins |
| bus_oe_o | output | 1 | Pad driver enable for bus_o |
| q_lo_o | output | 1 | Serial tap on bit 0 |
| q_hi_o | output | 1 | Serial tap on bit WIDTH-1 |

## Verification
The bench pushes a bit across the boundary between two chained instances in both directions. A slice that takes its neighbour or its serial input from the wrong side would break the 16-bit pattern right at that boundary. It checks that the load code turns the bus enable off even when both enables are low, and that shifting goes on while the enables are high. A design that gated state changes with the enables, or left the drivers on while loading, would show it there. Reset is asserted between clock edges in the middle of a shift and held across an edge with the load code set. This catches a synchronous reset, or a load that overrides reset.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;

  typedef struct packed {
    logic load;
    logic up;
    logic down;
  } usr_sel_t;
endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
  import usr_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       oe1_ni,
  input  logic       oe2_ni,
  output usr_sel_t   sel_o,
  output logic       bus_oe_o
);
  usr_mode_e mode;

  always_comb begin
    mode       = usr_mode_e'(mode_i);
    sel_o      = '0;
    sel_o.load = (mode == MODE_LOAD);
    sel_o.up   = (mode == MODE_UP);
    sel_o.down = (mode == MODE_DOWN);
  end

  // load code frees the pins for input
  assign bus_oe_o = ~oe1_ni & ~oe2_ni & ~sel_o.load;
endmodule

// File: rtl/usr_next_mux.sv
module usr_next_mux
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  usr_sel_t         sel_i,
  input  logic [WIDTH-1:0] q_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             sr_i,
  input  logic             sl_i,
  output logic [WIDTH-1:0] d_o
);
  logic [WIDTH-1:0] from_below;
  logic [WIDTH-1:0] from_above;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign from_below[i] = sr_i;
    end else begin : g_lo_n
      assign from_below[i] = q_i[i-1];
    end
    if (i == WIDTH - 1) begin : g_hi
      assign from_above[i] = sl_i;
    end else begin : g_hi_n
      assign from_above[i] = q_i[i+1];
    end

    always_comb begin
      unique case (1'b1)
        sel_i.load: d_o[i] = par_i[i];
        sel_i.up:   d_o[i] = from_below[i];
        sel_i.down: d_o[i] = from_above[i];
        default:    d_o[i] = q_i[i];
      endcase
    end
  end
endmodule

// File: rtl/usr_state_reg.sv
module usr_state_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             oe1_ni,
  input  logic             oe2_ni,
  input  logic             sr_i,
  input  logic             sl_i,
  input  logic [WIDTH-1:0] bus_i,
  output logic [WIDTH-1:0] bus_o,
  output logic             bus_oe_o,
  output logic             q_lo_o,
  output logic             q_hi_o
);
  localparam int MSB = WIDTH - 1;

  usr_sel_t         sel;
  logic [WIDTH-1:0] d;
  logic [WIDTH-1:0] q;

  usr_mode_dec u_dec (
    .mode_i  (mode_i),
    .oe1_ni  (oe1_ni),
    .oe2_ni  (oe2_ni),
    .sel_o   (sel),
    .bus_oe_o(bus_oe_o)
  );

  usr_next_mux #(.WIDTH(WIDTH)) u_mux (
    .sel_i(sel),
    .q_i  (q),
    .par_i(bus_i),
    .sr_i (sr_i),
    .sl_i (sl_i),
    .d_o  (d)
  );

  usr_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (d),
    .q_o   (q)
  );

  assign bus_o  = q;
  assign q_lo_o = q[0];
  assign q_hi_o = q[MSB];
endmodule

// File: rtl/usr_shift_reg_chk.sv
module usr_shift_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             oe1_ni,
  input logic             oe2_ni,
  input logic             sr_i,
  input logic             sl_i,
  input logic [WIDTH-1:0] bus_i,
  input logic [WIDTH-1:0] bus_o,
  input logic             bus_oe_o,
  input logic             q_lo_o,
  input logic             q_hi_o
);
  // R1
  load_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |=> bus_o == $past(bus_i));
  // R2
  shift_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b01 |=> bus_o == {$past(bus_o[WIDTH-2:0]), $past(sr_i)});
  // R3
  shift_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b10 |=> bus_o == {$past(sl_i), $past(bus_o[WIDTH-1:1])});
  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |=> $stable(bus_o));
  // R5
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> bus_o == '0);
  // R6
  load_oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |-> !bus_oe_o);
  // R6
  en_oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe1_ni || oe2_ni) |-> !bus_oe_o);
  // R8
  tap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_lo_o == bus_o[0] && q_hi_o == bus_o[WIDTH-1]);
endmodule

bind usr_shift_reg usr_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_usr_shift_reg.sv
module sim_usr_shift_reg;
  localparam int W = 8;

  typedef struct {
    logic [2*W-1:0] exp;
    logic           exp_oe;
    string          tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 2'b00;
  logic oe1 = 1, oe2 = 1, sr = 0, sl = 0;
  logic [W-1:0] b0 = '0, b1 = '0;
  logic [W-1:0] o0, o1;
  logic oe_0, oe_1, lo0, hi0, lo1, hi1;
  logic [2*W-1:0] model = '0;
  item_t sb[$];
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  usr_shift_reg #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .oe1_ni(oe1), .oe2_ni(oe2),
    .sr_i(sr), .sl_i(lo1), .bus_i(b0), .bus_o(o0), .bus_oe_o(oe_0),
    .q_lo_o(lo0), .q_hi_o(hi0));

  usr_shift_reg #(.WIDTH(W)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .oe1_ni(oe1), .oe2_ni(oe2),
    .sr_i(hi0), .sl_i(sl), .bus_i(b1), .bus_o(o1), .bus_oe_o(oe_1),
    .q_lo_o(lo1), .q_hi_o(hi1));

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic e1, input logic e2, input logic s_r,
                      input logic s_l, input logic [W-1:0] p0, input logic [W-1:0] p1,
                      input string tag);
    item_t it;
    mode = m; oe1 = e1; oe2 = e2; sr = s_r; sl = s_l; b0 = p0; b1 = p1;
    @(posedge clk);
    case (m)
      2'b11: model = {p1, p0};
      2'b01: model = {model[2*W-2:0], s_r};
      2'b10: model = {s_l, model[2*W-1:1]};
      default: ;
    endcase
    it.exp = model; it.exp_oe = !e1 && !e2 && (m != 2'b11); it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(o0 == it.exp[W-1:0], it.tag, {8'h0, o0}, {8'h0, it.exp[W-1:0]});
      chk(o1 == it.exp[2*W-1:W], "R9 upper half", {8'h0, o1}, {8'h0, it.exp[2*W-1:W]});
      chk({hi1, lo1, hi0, lo0} == {it.exp[2*W-1], it.exp[W], it.exp[W-1], it.exp[0]},
          "R8 taps", {12'h0, hi1, lo1, hi0, lo0},
          {12'h0, it.exp[2*W-1], it.exp[W], it.exp[W-1], it.exp[0]});
      chk(oe_0 == it.exp_oe && oe_1 == it.exp_oe, "R6 bus enable",
          {14'h0, oe_1, oe_0}, {15'h0, it.exp_oe});
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk({o1, o0} == '0, "R5 reset state", {o1, o0}, 16'h0);
    rst_n = 1;
    // R1 load, drivers forced off by load code
    step(2'b11, 0, 0, 0, 0, 8'hA5, 8'h3C, "R1 load");
    // R4 hold with bus driven
    step(2'b00, 0, 0, 1, 1, 8'hFF, 8'hFF, "R4 hold");
    step(2'b00, 0, 0, 0, 1, 8'h00, 8'h00, "R4 hold");
    // R2 shift up, crosses instance boundary
    step(2'b01, 0, 0, 1, 0, 8'h00, 8'h00, "R2 shift up");
    step(2'b01, 0, 0, 0, 1, 8'h00, 8'h00, "R2 shift up");
    step(2'b01, 0, 0, 1, 1, 8'h00, 8'h00, "R2 shift up");
    // R3 shift down
    step(2'b10, 0, 0, 0, 1, 8'h00, 8'h00, "R3 shift down");
    step(2'b10, 0, 0, 1, 0, 8'h00, 8'h00, "R3 shift down");
    step(2'b10, 0, 0, 0, 1, 8'h00, 8'h00, "R3 shift down");
    // R7 operations continue with drivers disabled
    step(2'b01, 1, 0, 1, 0, 8'h00, 8'h00, "R7 shift up oe1 high");
    step(2'b10, 0, 1, 0, 1, 8'h00, 8'h00, "R7 shift down oe2 high");
    step(2'b00, 1, 1, 1, 1, 8'h00, 8'h00, "R7 hold both high");
    step(2'b11, 1, 0, 0, 0, 8'h5A, 8'hC3, "R7 load oe1 high");
    // R9 walk a single one through all 16 positions and back
    step(2'b11, 0, 0, 0, 0, 8'h01, 8'h00, "R1 load one");
    for (int i = 0; i < 2 * W - 1; i++) step(2'b01, 0, 0, 0, 0, 8'h00, 8'h00, "R9 cascade up");
    for (int i = 0; i < 2 * W - 1; i++) step(2'b10, 0, 0, 0, 0, 8'h00, 8'h00, "R9 cascade down");
    step(2'b10, 0, 0, 1, 0, 8'h00, 8'h00, "R9 sl entry");
    // R5 reset mid-shift
    step(2'b01, 0, 0, 1, 0, 8'h00, 8'h00, "R2 shift up");
    step(2'b01, 0, 0, 1, 0, 8'h00, 8'h00, "R2 shift up");
    #3 rst_n = 0;
    #1 chk({o1, o0} == '0 && {hi1, lo1, hi0, lo0} == '0, "R5 async clear", {o1, o0}, 16'h0);
    mode = 2'b11; b0 = 8'hFF; b1 = 8'hFF;
    @(posedge clk); #2;
    chk({o1, o0} == '0, "R5 reset over load", {o1, o0}, 16'h0);
    @(negedge clk); #1;
    rst_n = 1; model = '0;
    step(2'b00, 0, 0, 0, 0, 8'h00, 8'h00, "R5 after reset hold");
    step(2'b11, 0, 0, 0, 0, 8'h81, 8'h18, "R1 load after reset");
    @(negedge clk); #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule